// File: doc/BRIEF.md
# Receive Word Buffer with Half-Word Readout

This block stores 32-bit words handed over by an upstream serial word receiver and passes them to a host. The host reads them over a 16-bit bus. The receiver raises a one-cycle end-of-word strobe together with a validated 32-bit word, and the buffer stores it. The host pulls each stored word out in two steps. It first reads the low half, then the high half, and only that second read retires the word.

Three active-low flags describe the buffer. Data-ready means at least one word is waiting. Half-full lets the host drain a block of words without polling. Full means every slot is taken. When the buffer is full, a newly arriving word does not stall the receiver and is not dropped. It replaces the most recently stored word, and all older words stay untouched.

Top module: `rx_word_fifo`

## Requirements
- R1: The default capacity is 32 words of 32 bits. After 31 writes into an empty buffer `full_no` is still high, and the 32nd write takes it low.
- R2: `data_rdy_no` goes low in the cycle after a write strobe into an empty buffer. It stays low until the last stored word has been retired by a high-half read.
- R3: A read pulse with `half_sel_i` = 0 returns word bits 15:0, and a read pulse with `half_sel_i` = 1 returns bits 31:16. `rd_data_o` updates on the clock edge that samples the pulse and holds its value otherwise.
- R4: Only a high-half read retires a word. A low-half read leaves all flags unchanged, and the same word is still presented afterwards.
- R5: Words are returned in the order they were written.
- R6: A write strobe while the buffer is full and no word is being retired overwrites the newest stored word. The 31 older words are returned unchanged.
- R7: `half_full_no` is low exactly while the buffer holds 16 or more words.
- R8: `full_no` is low exactly while the buffer holds 32 words, and a further write leaves it low.
- R9: A read pulse while the buffer is empty leaves `rd_data_o` at its previous value and moves no pointer. A word written afterwards is the next word returned.
- R10: A write strobe in the same cycle as a retiring read leaves the word count unchanged. On a full buffer both words are kept: the retired word is returned and the new word is queued after the others.
- R11: After reset the buffer is empty, all three flags are high and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_stb_i | input | 1 | One-cycle strobe: a validated received word is present |
| wr_word_i | input | 32 | Received word to store |
| rd_en_i | input | 1 | One-cycle host read pulse |
| half_sel_i | input | 1 | 0 selects bits 15:0, 1 selects bits 31:16 and retires the word |
| rd_data_o | output | 16 | Registered half-word returned to the host |
| data_rdy_no | output | 1 | Low while at least one word is stored |
| half_full_no | output | 1 | Low while 16 or more words are stored |
| full_no | output | 1 | Low while all slots are occupied |

## Verification
The bench builds the block with its default depth of 32 and word width of 32. At this size the half-full threshold of 16 and the full boundary at 32 can be reached with plain write loops. After each write the bench checks the flags against a queue model. Complete fills are followed by complete drains, so the overwrite of slot 32 is checked and so is the case of a simultaneous write and retire on a full buffer. Low-half re-reads and reads on an empty buffer exercise the rule that only the high-half read retires a word.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned DEF_DEPTH  = 32;
  localparam int unsigned DEF_WORD_W = 32;

  function automatic int unsigned idx_inc(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned idx_dec(int unsigned idx, int unsigned depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic          rd_en_i,
  input  logic          half_sel_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [PW-1:0] rd_addr_o,
  output logic          rd_fetch_o,
  output logic [CW-1:0] count_o
);
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic has_data, is_full, pop, push, ovw;

  assign has_data = (count_q != '0);
  assign is_full  = (count_q == CW'(DEPTH));
  assign pop      = rd_en_i & half_sel_i & has_data;
  // a retire in the same cycle frees the slot, so no overwrite then
  assign push     = wr_stb_i & (~is_full | pop);
  assign ovw      = wr_stb_i & is_full & ~pop;

  assign wr_en_o    = push | ovw;
  assign wr_addr_o  = ovw ? PW'(idx_dec(int'(wptr_q), DEPTH)) : wptr_q;
  assign rd_addr_o  = rptr_q;
  assign rd_fetch_o = rd_en_i & has_data;
  assign count_o    = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) wptr_q <= PW'(idx_inc(int'(wptr_q), DEPTH));
      if (pop)  rptr_q <= PW'(idx_inc(int'(rptr_q), DEPTH));
      unique case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned PW     = $clog2(DEPTH),
  parameter int unsigned HW     = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              rd_fetch_i,
  input  logic [PW-1:0]     rd_addr_i,
  input  logic              half_sel_i,
  output logic [HW-1:0]     rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_word;
  logic [HW-1:0]     half [2];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_word_i;
  end

  assign rd_word = mem_q[rd_addr_i];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = rd_word[h*HW +: HW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_data_o <= '0;
    else if (rd_fetch_i) rd_data_o <= half[half_sel_i];
  end
endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned HF_LEVEL = DEPTH / 2,
  parameter int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  output logic          data_rdy_no,
  output logic          half_full_no,
  output logic          full_no
);
  assign data_rdy_no  = (count_i == '0);
  assign half_full_no = (count_i < CW'(HF_LEVEL));
  assign full_no      = (count_i != CW'(DEPTH));
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_stb_i,
  input  logic [WORD_W-1:0]   wr_word_i,
  input  logic                rd_en_i,
  input  logic                half_sel_i,
  output logic [WORD_W/2-1:0] rd_data_o,
  output logic                data_rdy_no,
  output logic                half_full_no,
  output logic                full_no
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned HW = WORD_W / 2;

  logic          wr_en, rd_fetch;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] count;

  rx_fifo_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stb_i   (wr_stb_i),
    .rd_en_i    (rd_en_i),
    .half_sel_i (half_sel_i),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .rd_fetch_o (rd_fetch),
    .count_o    (count)
  );

  rx_fifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PW(PW), .HW(HW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_word_i  (wr_word_i),
    .rd_fetch_i (rd_fetch),
    .rd_addr_i  (rd_addr),
    .half_sel_i (half_sel_i),
    .rd_data_o  (rd_data_o)
  );

  rx_fifo_flags #(.DEPTH(DEPTH), .HF_LEVEL(DEPTH / 2), .CW(CW)) u_flags (
    .count_i      (count),
    .data_rdy_no  (data_rdy_no),
    .half_full_no (half_full_no),
    .full_no      (full_no)
  );
endmodule

// File: rtl/rx_word_fifo_chk.sv
module rx_word_fifo_chk #(
  parameter int unsigned HW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_stb_i,
  input logic          rd_en_i,
  input logic          half_sel_i,
  input logic [HW-1:0] rd_data_o,
  input logic          data_rdy_no,
  input logic          half_full_no,
  input logic          full_no
);
  // R2
  word_arrival_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !data_rdy_no);

  // R2
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_rdy_no && !(rd_en_i && half_sel_i)) |=> !data_rdy_no);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R4
  low_half_no_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !half_sel_i && !wr_stb_i) |=> $stable({data_rdy_no, half_full_no, full_no}));

  // R9
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && data_rdy_no) |=> $stable(rd_data_o));

  // R8
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_no && wr_stb_i) |=> !full_no);

  // R7
  flag_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> (!half_full_no && !data_rdy_no));
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.HW(WORD_W / 2)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_stb_i     (wr_stb_i),
  .rd_en_i      (rd_en_i),
  .half_sel_i   (half_sel_i),
  .rd_data_o    (rd_data_o),
  .data_rdy_no  (data_rdy_no),
  .half_full_no (half_full_no),
  .full_no      (full_no)
);

// File: tb/rx_word_fifo_test.sv
module rx_word_fifo_test;
  localparam int DEPTH = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic [31:0] wr_word_i = '0;
  logic        rd_en_i = 1'b0;
  logic        half_sel_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        data_rdy_no, half_full_no, full_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] q[$];

  always #10 clk_i = ~clk_i;

  rx_word_fifo #(.DEPTH(DEPTH), .WORD_W(32)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    logic [2:0] exp;
    exp = {q.size() == 0, q.size() < 16, q.size() != DEPTH};
    check({data_rdy_no, half_full_no, full_no} == exp, req, "flags",
          {29'd0, data_rdy_no, half_full_no, full_no}, {29'd0, exp});
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk_i);
    wr_stb_i = 1'b1; wr_word_i = w;
    @(negedge clk_i);
    wr_stb_i = 1'b0;
    if (q.size() < DEPTH) q.push_back(w);
    else q[q.size()-1] = w;
  endtask

  task automatic read_half(input bit sel, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; half_sel_i = sel;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic read_word(input string req);
    logic [15:0] lo, hi;
    logic [31:0] exp;
    exp = q[0];
    read_half(1'b0, lo);
    check(lo == exp[15:0], req, "low half", {16'd0, lo}, {16'd0, exp[15:0]});
    read_half(1'b1, hi);
    void'(q.pop_front());
    check(hi == exp[31:16], req, "high half", {16'd0, hi}, {16'd0, exp[31:16]});
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0000 ^ (32'(i) * 32'h0103_0507);
  endfunction

  task automatic t_reset();
    check_flags("R11");
    check(rd_data_o == 16'h0, "R11", "rd_data after reset", {16'd0, rd_data_o}, 32'd0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    write_word(32'h1234_5678);
    check(!data_rdy_no, "R2", "data_rdy after write", {31'd0, data_rdy_no}, 32'd0);
    write_word(32'hCAFE_BEEF);
    write_word(32'h0F0F_F0F0);
    read_half(1'b0, d);
    check(d == 16'h5678, "R3", "low half first", {16'd0, d}, 32'h5678);
    check_flags("R4");
    read_half(1'b0, d);
    check(d == 16'h5678, "R4", "low half re-read", {16'd0, d}, 32'h5678);
    read_half(1'b1, d);
    void'(q.pop_front());
    check(d == 16'h1234, "R3", "high half", {16'd0, d}, 32'h1234);
    repeat (3) @(negedge clk_i);
    check(rd_data_o == 16'h1234, "R3", "output held idle", {16'd0, rd_data_o}, 32'h1234);
    read_word("R5");
    check(!data_rdy_no, "R2", "data_rdy with one left", {31'd0, data_rdy_no}, 32'd0);
    read_word("R5");
    check_flags("R2");
  endtask

  task automatic t_empty_read();
    logic [15:0] d;
    read_half(1'b0, d);
    check(d == 16'h0F0F, "R9", "empty low read holds", {16'd0, d}, 32'h0F0F);
    read_half(1'b1, d);
    check(d == 16'h0F0F, "R9", "empty high read holds", {16'd0, d}, 32'h0F0F);
    check_flags("R9");
    write_word(32'h7777_1111);
    read_word("R9");
    check_flags("R9");
  endtask

  task automatic t_fill_overwrite();
    for (int i = 0; i < DEPTH; i++) begin
      write_word(pat(i));
      if (i == 14 || i == 15) check_flags("R7");
      if (i == 30) check_flags("R1");
      if (i == 31) check_flags("R8");
    end
    write_word(32'hDEAD_0001);
    check_flags("R8");
    write_word(32'hDEAD_0002);
    check_flags("R6");
    for (int i = 0; i < DEPTH; i++) begin
      read_word("R6");
      if (q.size() == 16 || q.size() == 15) check_flags("R7");
    end
    check_flags("R2");
  endtask

  task automatic t_simultaneous();
    logic [15:0] lo, hi;
    logic [31:0] exp;
    for (int i = 0; i < DEPTH; i++) write_word(pat(i + 100));
    exp = q[0];
    read_half(1'b0, lo);
    check(lo == exp[15:0], "R10", "low half before retire", {16'd0, lo}, {16'd0, exp[15:0]});
    @(negedge clk_i);
    wr_stb_i = 1'b1; wr_word_i = 32'hBEEF_0042;
    rd_en_i = 1'b1; half_sel_i = 1'b1;
    @(negedge clk_i);
    wr_stb_i = 1'b0; rd_en_i = 1'b0;
    hi = rd_data_o;
    void'(q.pop_front());
    q.push_back(32'hBEEF_0042);
    check(hi == exp[31:16], "R10", "retired word high half", {16'd0, hi}, {16'd0, exp[31:16]});
    check_flags("R10");
    for (int i = 0; i < DEPTH; i++) read_word("R10");
    check_flags("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_empty_read();
    t_fill_overwrite();
    t_simultaneous();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule